// File: doc/BRIEF.md
# Double-Precision Compare Unit

This unit compares two 64-bit IEEE-754 double-precision operands under one of four predicates: equality, strict less-than, less-or-equal, and unordered. A 2-bit operation select picks the predicate. The answer comes back as a full 64-bit word that is either the floating value 2.0 (true) or all zeros (false), so it can be written straight into a floating register file. An invalid flag comes with the answer.

Each operand is first sorted into one of six classes: signaling NaN, quiet NaN, infinity, zero, denormal, or normal. When neither operand is a NaN, the two are ordered by sign, then by the exponent field, then by the fraction field. Both zeros are treated as equal. Inputs are taken when `in_valid` is high, and the answer is registered and presented one cycle later with `out_valid`. Between accepted inputs, the result and flag keep their last value.

Top module: `dcmp_unit`

## Requirements
- R1: `result` only ever carries 0x4000000000000000 (true, only bit 62 set) or 0x0000000000000000 (false).
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: When either operand is a signaling NaN (exponent field all ones, fraction nonzero, fraction bit 51 clear), `invalid` is set, and the predicates equal, less-than and less-or-equal return false.
- R4: When at least one operand is a quiet NaN (exponent all ones, fraction bit 51 set) and neither is a signaling NaN, `invalid` is clear, the predicates equal, less-than and less-or-equal return false, and unordered returns true.
- R5: +0 and -0 compare equal, neither is less than the other, and each is less-or-equal to the other.
- R6: When both operands are negative, A is less than B if A has a larger exponent field, or the same exponent field and a larger fraction.
- R7: When both operands are positive, A is less than B if A has a smaller exponent field, or the same exponent field and a smaller fraction.
- R8: A negative operand is less than a positive operand unless both are zeros. A positive operand is never less than a negative one.
- R9: Infinities and denormals are ordered values. An infinity equals an infinity of the same sign and lies beyond every finite value of its sign. A denormal lies above zero and below every normal of its sign.
- R10: Unordered returns true and raises `invalid` when a signaling NaN is present, and returns false with no flag when both operands are non-NaN.
- R11: The operation select encoding is 0 = equal, 1 = less-than, 2 = less-or-equal, 3 = unordered. Less-or-equal is true exactly when equal or less-than is true.
- R12: While `rst_n` is low, `out_valid`, `result` and `invalid` are all zero.
- R13: In a cycle with `in_valid` low, the operands and select are ignored: `result` and `invalid` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and select are taken this cycle |
| op_sel | input | 2 | Predicate: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered |
| opnd_a | input | 64 | Left operand (double) |
| opnd_b | input | 64 | Right operand (double) |
| out_valid | output | 1 | Result and flag belong to the input of the previous cycle |
| result | output | 64 | 0x4000000000000000 for true, zero for false |
| invalid | output | 1 | A signaling NaN was seen among the operands |

## Verification
Every answer, including `invalid`, is due exactly one rising edge after the cycle in which `in_valid` was high. The bench drives each input on a falling edge and reads the outputs on the next falling edge, halfway between that capture edge and the one after it. Back-to-back inputs are checked one per cycle on that same half-cycle offset. The idle cycles that follow are checked at the same offset, with the operands changed, to confirm that `result` and `invalid` hold and that `out_valid` stays low.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

    typedef enum logic [2:0] {
        CLS_SNAN   = 3'd0,
        CLS_QNAN   = 3'd1,
        CLS_INF    = 3'd2,
        CLS_ZERO   = 3'd3,
        CLS_DENORM = 3'd4,
        CLS_NORMAL = 3'd5
    } fp_class_e;

    typedef enum logic [1:0] {
        OP_EQ = 2'd0,
        OP_LT = 2'd1,
        OP_LE = 2'd2,
        OP_UN = 2'd3
    } cmp_op_e;

endpackage

// File: rtl/dcmp_classify.sv
module dcmp_classify
    import dcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic [DATA_W-1:0] val_i,
    output fp_class_e         cls_o,
    output logic              sign_o,
    output logic [DATA_W-2:0] mag_o
);
    localparam int FRAC_W = DATA_W - 1 - EXP_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_zero;
    logic              exp_ones;
    logic              frac_zero;

    assign exp_f     = val_i[DATA_W-2 -: EXP_W];
    assign frac_f    = val_i[FRAC_W-1:0];
    assign exp_zero  = (exp_f == '0);
    assign exp_ones  = (exp_f == '1);
    assign frac_zero = (frac_f == '0);
    assign sign_o    = val_i[DATA_W-1];
    assign mag_o     = val_i[DATA_W-2:0];

    always_comb begin
        if (exp_zero) begin
            cls_o = frac_zero ? CLS_ZERO : CLS_DENORM;
        end else if (exp_ones) begin
            if (frac_zero)                cls_o = CLS_INF;
            else if (frac_f[FRAC_W-1])    cls_o = CLS_QNAN;
            else                          cls_o = CLS_SNAN;
        end else begin
            cls_o = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/dcmp_order.sv
module dcmp_order #(
    parameter int DATA_W = 64
) (
    input  logic              sign_a_i,
    input  logic              sign_b_i,
    input  logic [DATA_W-2:0] mag_a_i,
    input  logic [DATA_W-2:0] mag_b_i,
    input  logic              zero_a_i,
    input  logic              zero_b_i,
    output logic              eq_o,
    output logic              lt_o
);
    logic both_zero;
    logic mag_lt;
    logic mag_gt;
    logic mag_eq;

    assign both_zero = zero_a_i && zero_b_i;
    assign mag_lt    = (mag_a_i <  mag_b_i);
    assign mag_gt    = (mag_a_i >  mag_b_i);
    assign mag_eq    = (mag_a_i == mag_b_i);

    always_comb begin
        eq_o = both_zero || ((sign_a_i == sign_b_i) && mag_eq);
        unique case ({sign_a_i, sign_b_i})
            2'b10:   lt_o = !both_zero;
            2'b01:   lt_o = 1'b0;
            2'b11:   lt_o = mag_gt;
            default: lt_o = mag_lt;
        endcase
    end

endmodule

// File: rtl/dcmp_unit.sv
module dcmp_unit
    import dcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              invalid
);
    localparam int          N_OPND = 2;
    localparam logic [DATA_W-1:0] TRUE_WORD = {2'b01, {(DATA_W-2){1'b0}}};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] word;
        logic              inv;
    } state_t;

    logic [DATA_W-1:0] opnd   [N_OPND];
    fp_class_e         cls    [N_OPND];
    logic              sgn    [N_OPND];
    logic [DATA_W-2:0] mag    [N_OPND];

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        dcmp_classify #(
            .DATA_W (DATA_W),
            .EXP_W  (EXP_W)
        ) u_cls (
            .val_i  (opnd[gi]),
            .cls_o  (cls[gi]),
            .sign_o (sgn[gi]),
            .mag_o  (mag[gi])
        );
    end

    logic ord_eq;
    logic ord_lt;

    dcmp_order #(
        .DATA_W (DATA_W)
    ) u_ord (
        .sign_a_i (sgn[0]),
        .sign_b_i (sgn[1]),
        .mag_a_i  (mag[0]),
        .mag_b_i  (mag[1]),
        .zero_a_i (cls[0] == CLS_ZERO),
        .zero_b_i (cls[1] == CLS_ZERO),
        .eq_o     (ord_eq),
        .lt_o     (ord_lt)
    );

    logic    any_snan;
    logic    any_qnan;
    cmp_op_e op;

    assign any_snan = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);
    assign any_qnan = (cls[0] == CLS_QNAN) || (cls[1] == CLS_QNAN);
    assign op       = cmp_op_e'(op_sel);

    state_t st_d;
    state_t st_q;
    logic   truth_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        truth_d  = 1'b0;
        if (any_snan || any_qnan) begin
            truth_d = (op == OP_UN);
        end else begin
            unique case (op)
                OP_EQ:   truth_d = ord_eq;
                OP_LT:   truth_d = ord_lt;
                OP_LE:   truth_d = ord_lt || ord_eq;
                default: truth_d = 1'b0;
            endcase
        end
        if (in_valid) begin
            st_d.word = truth_d ? TRUE_WORD : '0;
            st_d.inv  = any_snan;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.word;
    assign invalid   = st_q.inv;

    // Assertions
    assert_true_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result == '0 || result == TRUE_WORD));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_snan_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_snan) |=> invalid);

    assert_quiet_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_snan) |=> !invalid);

    assert_zero_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls[0] == CLS_ZERO && cls[1] == CLS_ZERO && op == OP_EQ)
        |=> (result == TRUE_WORD));

    assert_eq_lt_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_snan && !any_qnan) |-> !(ord_eq && ord_lt));

    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(invalid)));

endmodule

// File: tb/sim_dcmp_unit.sv
module sim_dcmp_unit;
    localparam int CLK_P = 10;

    localparam logic [63:0] P1   = 64'h3FF0000000000000;
    localparam logic [63:0] P15  = 64'h3FF8000000000000;
    localparam logic [63:0] P2   = 64'h4000000000000000;
    localparam logic [63:0] N1   = 64'hBFF0000000000000;
    localparam logic [63:0] N15  = 64'hBFF8000000000000;
    localparam logic [63:0] N2   = 64'hC000000000000000;
    localparam logic [63:0] PZ   = 64'h0000000000000000;
    localparam logic [63:0] NZ   = 64'h8000000000000000;
    localparam logic [63:0] PINF = 64'h7FF0000000000000;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;
    localparam logic [63:0] QN   = 64'h7FF8000000000000;
    localparam logic [63:0] SN   = 64'h7FF0000000000001;
    localparam logic [63:0] DEN  = 64'h0000000000000001;
    localparam logic [63:0] TW   = 64'h4000000000000000;

    // {op, a, b, expect_true, expect_invalid}
    localparam int NV = 30;
    localparam logic [131:0] VEC [NV] = '{
        {2'd0, P1,   P1,   1'b1, 1'b0},  // R11 eq
        {2'd0, P1,   P2,   1'b0, 1'b0},  // R11
        {2'd1, P1,   P2,   1'b1, 1'b0},  // R7 exponent
        {2'd1, P1,   P15,  1'b1, 1'b0},  // R7 fraction
        {2'd1, P15,  P1,   1'b0, 1'b0},  // R7
        {2'd1, N2,   N1,   1'b1, 1'b0},  // R6 exponent
        {2'd1, N1,   N15,  1'b0, 1'b0},  // R6
        {2'd1, N15,  N1,   1'b1, 1'b0},  // R6 fraction
        {2'd2, N1,   N1,   1'b1, 1'b0},  // R11 le equal
        {2'd1, N1,   P1,   1'b1, 1'b0},  // R8
        {2'd1, P1,   N1,   1'b0, 1'b0},  // R8
        {2'd0, PZ,   NZ,   1'b1, 1'b0},  // R5
        {2'd1, NZ,   PZ,   1'b0, 1'b0},  // R5
        {2'd2, NZ,   PZ,   1'b1, 1'b0},  // R5
        {2'd2, PZ,   NZ,   1'b1, 1'b0},  // R5
        {2'd1, DEN,  P1,   1'b1, 1'b0},  // R9
        {2'd1, PZ,   DEN,  1'b1, 1'b0},  // R9
        {2'd0, PINF, PINF, 1'b1, 1'b0},  // R9
        {2'd1, P1,   PINF, 1'b1, 1'b0},  // R9
        {2'd1, NINF, N1,   1'b1, 1'b0},  // R9
        {2'd0, QN,   P1,   1'b0, 1'b0},  // R4
        {2'd1, P1,   QN,   1'b0, 1'b0},  // R4
        {2'd3, QN,   P1,   1'b1, 1'b0},  // R4
        {2'd3, P1,   P2,   1'b0, 1'b0},  // R10
        {2'd0, SN,   P1,   1'b0, 1'b1},  // R3
        {2'd2, P1,   SN,   1'b0, 1'b1},  // R3
        {2'd3, SN,   QN,   1'b1, 1'b1},  // R10
        {2'd1, NZ,   P1,   1'b1, 1'b0},  // R8
        {2'd2, P2,   P1,   1'b0, 1'b0},  // R11
        {2'd0, N1,   P1,   1'b0, 1'b0}   // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dcmp_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .result    (result),
        .invalid   (invalid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
        in_valid = 1'b1;
        op_sel   = op;
        opnd_a   = a;
        opnd_b   = b;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 out_valid", {63'd0, out_valid}, 64'd0);
        check("R12 result", result, 64'd0);
        check("R12 invalid", {63'd0, invalid}, 64'd0);
        rst_n = 1'b1;

        // Table walk: one vector, then check on the next falling edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][131:130], VEC[i][129:66], VEC[i][65:2]);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R2 vec%0d out_valid", i), {63'd0, out_valid}, 64'd1);
            check($sformatf("R1 vec%0d result", i), result, VEC[i][1] ? TW : 64'd0);
            check($sformatf("R3/R4 vec%0d invalid", i), {63'd0, invalid}, {63'd0, VEC[i][0]});
        end

        // R13: idle cycles with changed operands hold result and flag
        @(negedge clk);
        drive(2'd3, SN, SN);
        @(negedge clk);
        in_valid = 1'b0;
        op_sel   = 2'd0;
        opnd_a   = P1;
        opnd_b   = P2;
        @(negedge clk);
        check("R13 result held", result, TW);
        check("R13 invalid held", {63'd0, invalid}, 64'd1);
        check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check("R13 result held 2", result, TW);

        // Back-to-back inputs, one answer per cycle
        @(negedge clk);
        drive(2'd1, N1, P1);
        @(negedge clk);
        check("R8 b2b first", result, TW);
        drive(2'd0, P1, P2);
        @(negedge clk);
        check("R11 b2b second", result, 64'd0);
        check("R2 b2b valid", {63'd0, out_valid}, 64'd1);
        drive(2'd3, P1, P1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 b2b unordered false", result, 64'd0);
        check("R10 b2b invalid clear", {63'd0, invalid}, 64'd0);

        // R12: reset mid-stream clears state
        @(negedge clk);
        drive(2'd0, P1, P1);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R12 reset result", result, 64'd0);
        check("R12 reset out_valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule